// File: doc/BRIEF.md
# Dispatch Group Hazard Checker

This block keeps track of how a five-slot, in-order dispatch group fills up, one instruction at a time. It is used by a scheduler. For each candidate instruction the scheduler presents a class code and a few flags. The block answers straight away with one of three verdicts:
- clear: the instruction can go into the current group;
- hazard: the group has to be closed before this instruction can go in;
- noop: a filler should be inserted to avoid a costly pipeline flush.

The block holds the state of the open group. This state is the number of slots used and a count of instructions per execution unit. It also holds two flags: whether a counter register has been written, and whether a store has issued.

Three strobes change that state:
- The issue strobe records the candidate in the group.
- The advance strobe uses up one slot without an instruction. It is used for a noop or an idle cycle.
- The block-start input opens a fresh group.

Checking whether a load address overlaps a store address is done outside the block. The result arrives as a flag.

Top module: `dgrp_hazard_chk`

## Requirements
- R1: A synchronous reset (`rst_i`) or `blk_start_i` clears the group state at the next rising edge. After that, `slots_o` reads 0 and no unit or flag remains recorded. Verdict codes on `verdict_o`: 0 = clear, 1 = hazard, 2 = noop.
- R2: Class codes on `cand_cls_i`: 1 fixed-point, 2 lead-only fixed-point (e.g. divide), 3 load, 4 store, 5 floating-point, 6 condition-register, 7 special-register, 8 vector ALU, 9 vector permute, 10 branch. Codes 1 and 2 share a limit of 2 per group, codes 3 and 4 share a limit of 2, code 5 has a limit of 2, and codes 6 to 9 each have a limit of 1. A candidate whose unit is already at its limit gets the hazard verdict.
- R3: Classes 2, 6 and 7 get the hazard verdict unless no slot of the group has been used yet.
- R4: When four slots are used, every class except branch (10) gets the hazard verdict. A branch in that position gets clear.
- R5: An accepted branch issue closes the group, so `slots_o` reads 0 after the edge.
- R6: `cand_sets_ctr_i` on an accepted issue marks the counter register as written for the rest of the group. A branch candidate with `cand_br_ctr_i` high then gets the noop verdict. Without the mark it gets clear.
- R7: A load candidate (3) with `cand_overlap_i` high gets the noop verdict only if a store (4) has been accepted in the current group. Otherwise it gets clear.
- R8: An advance with no issue adds one slot. When the fifth slot is used, the group closes and all counters and flags are cleared.
- R9: Class 0 and codes 11 to 15 are pseudo instructions. They always get clear, and an issue of one changes no state.
- R10: The hazard verdict takes priority over the noop verdict.
- R11: An issue while the verdict is hazard is ignored, and the state is left unchanged.
- R12: `adv_err_o` is high whenever `advance_i` and `issue_i` are high together. In that case the advance is discarded and only the issue takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| blk_start_i | input | 1 | Start of a new block; opens a fresh group |
| issue_i | input | 1 | Record the candidate in the group |
| advance_i | input | 1 | Consume one slot with no instruction |
| cand_cls_i | input | 4 | Candidate class code |
| cand_sets_ctr_i | input | 1 | Candidate writes the counter register |
| cand_br_ctr_i | input | 1 | Candidate branches through the counter register |
| cand_overlap_i | input | 1 | Candidate load overlaps the recorded store address |
| verdict_o | output | 2 | 0 clear, 1 hazard, 2 noop |
| slots_o | output | 3 | Slots used in the open group |
| adv_err_o | output | 1 | Advance and issue asserted in the same cycle |

## Verification
`verdict_o` and `adv_err_o` are combinational. They are due in the same cycle that the candidate is presented. `slots_o` and every later verdict reflect a strobe only after the next rising edge.

The bench drives inputs at the falling edge and compares both combinational outputs against its model 2 ns later, well before the rising edge. It advances its model at the rising edge and reads `slots_o` 1 ns after that edge. This means each check sees exactly one edge's worth of state change.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

  typedef enum logic [3:0] {
    CLS_PSEUDO   = 4'd0,
    CLS_FIX      = 4'd1,
    CLS_FIX_LEAD = 4'd2,
    CLS_LOAD     = 4'd3,
    CLS_STORE    = 4'd4,
    CLS_FLT      = 4'd5,
    CLS_CR       = 4'd6,
    CLS_SPR      = 4'd7,
    CLS_VALU     = 4'd8,
    CLS_VPERM    = 4'd9,
    CLS_BRANCH   = 4'd10
  } icls_e;

  typedef enum logic [1:0] {
    VD_CLEAR  = 2'd0,
    VD_HAZARD = 2'd1,
    VD_NOOP   = 2'd2
  } verdict_e;

  typedef struct packed {
    logic cr;
    logic spr;
    logic valu;
    logic vperm;
    logic ctr_set;
    logic store_seen;
  } grp_flags_t;

  // A class code that names a real unit; everything else is a pseudo op.
  function automatic logic is_known(logic [3:0] c);
    return (c != 4'd0) && (c <= 4'd10);
  endfunction

  // Classes that may only open a group.
  function automatic logic lead_only(logic [3:0] c);
    return (c == 4'(CLS_CR)) || (c == 4'(CLS_SPR)) || (c == 4'(CLS_FIX_LEAD));
  endfunction

  function automatic logic at_cap(int cnt, int cap);
    return cnt >= cap;
  endfunction

endpackage

// File: rtl/dgrp_verdict.sv
module dgrp_verdict
  import dgrp_pkg::*;
#(
  parameter int SLOTS  = 5,
  parameter int FIX_MAX = 2,
  parameter int LS_MAX  = 2,
  parameter int FP_MAX  = 2,
  parameter int SW  = $clog2(SLOTS + 1),
  parameter int FXW = $clog2(FIX_MAX + 1),
  parameter int LSW = $clog2(LS_MAX + 1),
  parameter int FPW = $clog2(FP_MAX + 1)
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [3:0]     cls_i,
  input  logic           br_ctr_i,
  input  logic           overlap_i,
  input  logic [SW-1:0]  slots_i,
  input  logic [FXW-1:0] fx_i,
  input  logic [LSW-1:0] ls_i,
  input  logic [FPW-1:0] fp_i,
  input  grp_flags_t     flags_i,
  output verdict_e       verdict_o,
  output logic           unit_full_o,
  output logic           slot_block_o,
  output logic           noop_ctr_o,
  output logic           noop_ovl_o
);

  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  logic known;
  assign known = is_known(cls_i);

  always_comb begin
    unit_full_o = 1'b0;
    case (cls_i)
      4'(CLS_FIX), 4'(CLS_FIX_LEAD): unit_full_o = at_cap(int'(fx_i), FIX_MAX);
      4'(CLS_LOAD), 4'(CLS_STORE):   unit_full_o = at_cap(int'(ls_i), LS_MAX);
      4'(CLS_FLT):                   unit_full_o = at_cap(int'(fp_i), FP_MAX);
      4'(CLS_CR):                    unit_full_o = flags_i.cr;
      4'(CLS_SPR):                   unit_full_o = flags_i.spr;
      4'(CLS_VALU):                  unit_full_o = flags_i.valu;
      4'(CLS_VPERM):                 unit_full_o = flags_i.vperm;
      default:                       unit_full_o = 1'b0;
    endcase
  end

  always_comb begin
    slot_block_o = 1'b0;
    if (lead_only(cls_i) && (slots_i != '0))
      slot_block_o = 1'b1;
    if ((slots_i == LAST_SLOT) && (cls_i != 4'(CLS_BRANCH)))
      slot_block_o = 1'b1;
  end

  assign noop_ctr_o = (cls_i == 4'(CLS_BRANCH)) && br_ctr_i && flags_i.ctr_set;
  assign noop_ovl_o = (cls_i == 4'(CLS_LOAD)) && overlap_i && flags_i.store_seen;

  always_comb begin
    if (!known)
      verdict_o = VD_CLEAR;
    else if (unit_full_o || slot_block_o)
      verdict_o = VD_HAZARD;
    else if (noop_ctr_o || noop_ovl_o)
      verdict_o = VD_NOOP;
    else
      verdict_o = VD_CLEAR;
  end

  // R3: lead-only classes past the first slot must be refused
  p_lead_first_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (lead_only(cls_i) && slots_i != '0) |-> verdict_o == VD_HAZARD);

  // R9: pseudo classes never raise anything
  p_pseudo_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !is_known(cls_i) |-> verdict_o == VD_CLEAR);

  // R10: a unit conflict beats a flush-avoidance filler
  p_prio_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (unit_full_o && (noop_ctr_o || noop_ovl_o)) |-> verdict_o == VD_HAZARD);

endmodule

// File: rtl/dgrp_state.sv
module dgrp_state
  import dgrp_pkg::*;
#(
  parameter int SLOTS   = 5,
  parameter int FIX_MAX = 2,
  parameter int LS_MAX  = 2,
  parameter int FP_MAX  = 2,
  parameter int SW  = $clog2(SLOTS + 1),
  parameter int FXW = $clog2(FIX_MAX + 1),
  parameter int LSW = $clog2(LS_MAX + 1),
  parameter int FPW = $clog2(FP_MAX + 1)
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           blk_i,
  input  logic           accept_i,
  input  logic           adv_i,
  input  logic [3:0]     cls_i,
  input  logic           sets_ctr_i,
  output logic [SW-1:0]  slots_o,
  output logic [FXW-1:0] fx_o,
  output logic [LSW-1:0] ls_o,
  output logic [FPW-1:0] fp_o,
  output grp_flags_t     flags_o,
  output logic           grp_close_o
);

  localparam logic [SW-1:0] FULL = SW'(SLOTS);

  logic [SW-1:0]  slots_q, slots_d;
  logic [FXW-1:0] fx_q, fx_d;
  logic [LSW-1:0] ls_q, ls_d;
  logic [FPW-1:0] fp_q, fp_d;
  grp_flags_t     fl_q, fl_d;
  logic           clear;

  assign clear = rst_i || blk_i;

  always_comb begin
    slots_d     = slots_q;
    fx_d        = fx_q;
    ls_d        = ls_q;
    fp_d        = fp_q;
    fl_d        = fl_q;
    grp_close_o = 1'b0;
    if (accept_i) begin
      case (cls_i)
        4'(CLS_FIX), 4'(CLS_FIX_LEAD): fx_d = fx_q + 1'b1;
        4'(CLS_LOAD):  ls_d = ls_q + 1'b1;
        4'(CLS_STORE): begin
          ls_d = ls_q + 1'b1;
          fl_d.store_seen = 1'b1;
        end
        4'(CLS_FLT):    fp_d = fp_q + 1'b1;
        4'(CLS_CR):     fl_d.cr = 1'b1;
        4'(CLS_SPR):    fl_d.spr = 1'b1;
        4'(CLS_VALU):   fl_d.valu = 1'b1;
        4'(CLS_VPERM):  fl_d.vperm = 1'b1;
        4'(CLS_BRANCH): grp_close_o = 1'b1;
        default: ;
      endcase
      if (sets_ctr_i)
        fl_d.ctr_set = 1'b1;
      slots_d = slots_q + 1'b1;
    end else if (adv_i) begin
      slots_d = slots_q + 1'b1;
    end
    if (slots_d == FULL)
      grp_close_o = 1'b1;
    if (grp_close_o) begin
      slots_d = '0;
      fx_d    = '0;
      ls_d    = '0;
      fp_d    = '0;
      fl_d    = '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (clear) begin
      slots_q <= '0;
      fx_q    <= '0;
      ls_q    <= '0;
      fp_q    <= '0;
      fl_q    <= '0;
    end else begin
      slots_q <= slots_d;
      fx_q    <= fx_d;
      ls_q    <= ls_d;
      fp_q    <= fp_d;
      fl_q    <= fl_d;
    end
  end

  assign slots_o = slots_q;
  assign fx_o    = fx_q;
  assign ls_o    = ls_q;
  assign fp_o    = fp_q;
  assign flags_o = fl_q;

  // R8: the open group never holds a full set of slots across an edge
  p_slot_bound_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    slots_q < FULL);

  // R2: unit counters stay within their limits
  p_fix_cap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(fx_q) <= FIX_MAX && int'(ls_q) <= LS_MAX && int'(fp_q) <= FP_MAX);

  // R5: an accepted branch leaves an empty group behind
  p_branch_close_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (accept_i && cls_i == 4'(CLS_BRANCH)) |=> slots_q == '0);

  // R8: a plain advance below the last slot moves the count by one
  p_adv_step_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !accept_i && !blk_i && slots_q < SW'(SLOTS - 1))
      |=> slots_q == $past(slots_q) + 1'b1);

endmodule

// File: rtl/dgrp_hazard_chk.sv
module dgrp_hazard_chk
  import dgrp_pkg::*;
#(
  parameter int SLOTS   = 5,
  parameter int FIX_MAX = 2,
  parameter int LS_MAX  = 2,
  parameter int FP_MAX  = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       blk_start_i,
  input  logic       issue_i,
  input  logic       advance_i,
  input  logic [3:0] cand_cls_i,
  input  logic       cand_sets_ctr_i,
  input  logic       cand_br_ctr_i,
  input  logic       cand_overlap_i,
  output logic [1:0] verdict_o,
  output logic [2:0] slots_o,
  output logic       adv_err_o
);

  localparam int SW  = $clog2(SLOTS + 1);
  localparam int FXW = $clog2(FIX_MAX + 1);
  localparam int LSW = $clog2(LS_MAX + 1);
  localparam int FPW = $clog2(FP_MAX + 1);

  logic [SW-1:0]  slots;
  logic [FXW-1:0] fx_cnt;
  logic [LSW-1:0] ls_cnt;
  logic [FPW-1:0] fp_cnt;
  grp_flags_t     flags;
  verdict_e       verdict;
  logic           unit_full, slot_block, noop_ctr, noop_ovl;
  logic           accept, adv_step, grp_close;

  dgrp_verdict #(
    .SLOTS(SLOTS), .FIX_MAX(FIX_MAX), .LS_MAX(LS_MAX), .FP_MAX(FP_MAX),
    .SW(SW), .FXW(FXW), .LSW(LSW), .FPW(FPW)
  ) u_verdict (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .cls_i        (cand_cls_i),
    .br_ctr_i     (cand_br_ctr_i),
    .overlap_i    (cand_overlap_i),
    .slots_i      (slots),
    .fx_i         (fx_cnt),
    .ls_i         (ls_cnt),
    .fp_i         (fp_cnt),
    .flags_i      (flags),
    .verdict_o    (verdict),
    .unit_full_o  (unit_full),
    .slot_block_o (slot_block),
    .noop_ctr_o   (noop_ctr),
    .noop_ovl_o   (noop_ovl)
  );

  // A refused or pseudo issue leaves the group alone; issue beats advance.
  assign accept   = issue_i && is_known(cand_cls_i) && (verdict != VD_HAZARD);
  assign adv_step = advance_i && !issue_i;

  dgrp_state #(
    .SLOTS(SLOTS), .FIX_MAX(FIX_MAX), .LS_MAX(LS_MAX), .FP_MAX(FP_MAX),
    .SW(SW), .FXW(FXW), .LSW(LSW), .FPW(FPW)
  ) u_state (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .blk_i       (blk_start_i),
    .accept_i    (accept),
    .adv_i       (adv_step),
    .cls_i       (cand_cls_i),
    .sets_ctr_i  (cand_sets_ctr_i),
    .slots_o     (slots),
    .fx_o        (fx_cnt),
    .ls_o        (ls_cnt),
    .fp_o        (fp_cnt),
    .flags_o     (flags),
    .grp_close_o (grp_close)
  );

  assign verdict_o = 2'(verdict);
  assign slots_o   = 3'(slots);
  assign adv_err_o = advance_i && issue_i;

  // R11: an issue that the verdict refuses leaves the slot count untouched
  p_ignore_haz_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_i && verdict == VD_HAZARD && !blk_start_i) |=> $stable(slots_o));

  // R12: with both strobes up, a pseudo issue means nothing moves at all
  p_adv_discard_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_err_o && !is_known(cand_cls_i) && !blk_start_i) |=> $stable(slots_o));

  // R1: block start empties the group at the next edge
  p_blk_clear_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    blk_start_i |=> slots_o == 3'd0);

  // R5: a closing group always comes back empty
  p_close_empty_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    grp_close |=> (slots_o == 3'd0 && fx_cnt == '0 && ls_cnt == '0 && fp_cnt == '0));

endmodule

// File: tb/dgrp_hazard_chk_test.sv
module dgrp_hazard_chk_test;

  logic       clk = 1'b0;
  logic       rst, blk, iss, adv, sctr, bctr, ovl;
  logic [3:0] cls;
  logic [1:0] verdict;
  logic [2:0] slots;
  logic       aerr;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int m_slots, m_fx, m_ls, m_fp;
  bit m_cr, m_spr, m_va, m_vp, m_ctr, m_st;

  always #10ns clk = ~clk;

  dgrp_hazard_chk uut (
    .clk_i(clk), .rst_i(rst), .blk_start_i(blk), .issue_i(iss),
    .advance_i(adv), .cand_cls_i(cls), .cand_sets_ctr_i(sctr),
    .cand_br_ctr_i(bctr), .cand_overlap_i(ovl),
    .verdict_o(verdict), .slots_o(slots), .adv_err_o(aerr)
  );

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_clear();
    m_slots = 0; m_fx = 0; m_ls = 0; m_fp = 0;
    m_cr = 0; m_spr = 0; m_va = 0; m_vp = 0; m_ctr = 0; m_st = 0;
  endtask

  function automatic int m_verdict(int c, bit b, bit o);
    bit haz;
    if (c < 1 || c > 10) return 0;
    case (c)
      1, 2:    haz = (m_fx >= 2);
      3, 4:    haz = (m_ls >= 2);
      5:       haz = (m_fp >= 2);
      6:       haz = m_cr;
      7:       haz = m_spr;
      8:       haz = m_va;
      9:       haz = m_vp;
      default: haz = 0;
    endcase
    if ((c == 2 || c == 6 || c == 7) && m_slots != 0) haz = 1;
    if (m_slots == 4 && c != 10) haz = 1;
    if (haz) return 1;
    if ((c == 10 && b && m_ctr) || (c == 3 && o && m_st)) return 2;
    return 0;
  endfunction

  // Drive at the falling edge, check combinational outputs, then take the edge.
  task automatic step(int c, bit i, bit a, bit sc, bit b, bit o, bit bk, bit r,
                      int exp_v, string tag);
    int mv;
    @(negedge clk);
    cls = 4'(c); iss = i; adv = a; sctr = sc; bctr = b; ovl = o; blk = bk; rst = r;
    #2ns;
    mv = m_verdict(c, b, o);
    if (!r) begin
      check(int'(verdict), mv, {tag, " verdict vs model"});
      check(int'(aerr), int'(i && a), {tag, " adv_err R12"});
      if (exp_v >= 0) check(int'(verdict), exp_v, {tag, " verdict"});
    end
    @(posedge clk);
    if (r || bk) m_clear();
    else if (i) begin
      if (c >= 1 && c <= 10 && mv != 1) begin
        case (c)
          1, 2: m_fx++;
          3:    m_ls++;
          4:    begin m_ls++; m_st = 1; end
          5:    m_fp++;
          6:    m_cr = 1;
          7:    m_spr = 1;
          8:    m_va = 1;
          9:    m_vp = 1;
          default: ;
        endcase
        if (sc) m_ctr = 1;
        m_slots++;
        if (c == 10 || m_slots == 5) m_clear();
      end
    end else if (a) begin
      m_slots++;
      if (m_slots == 5) m_clear();
    end
    #1ns;
    if (!r) check(int'(slots), m_slots, {tag, " slots vs model"});
  endtask

  task automatic go(int c, string tag);       // plain accepted issue
    step(c, 1, 0, 0, 0, 0, 0, 0, -1, tag);
  endtask
  task automatic probe(int c, bit b, bit o, int exp_v, string tag);
    step(c, 0, 0, 0, b, o, 0, 0, exp_v, tag);
  endtask
  task automatic newblk();
    step(0, 0, 0, 0, 0, 0, 1, 0, -1, "R1");
  endtask

  initial begin
    #(20ns * 50000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_clear();
    cls = 0; iss = 0; adv = 0; sctr = 0; bctr = 0; ovl = 0; blk = 0; rst = 1;
    step(0, 0, 0, 0, 0, 0, 0, 1, -1, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 1, -1, "R1");
    check(int'(slots), 0, "R1 reset slots");

    // R2 unit limits
    go(1, "R2"); go(1, "R2");
    probe(1, 0, 0, 1, "R2 third fixed");
    step(1, 1, 0, 0, 0, 0, 0, 0, 1, "R11 refused issue");
    check(int'(slots), 2, "R11 slots unchanged");
    newblk();
    check(int'(slots), 0, "R1 block start");
    go(3, "R2"); go(4, "R2");
    probe(3, 0, 0, 1, "R2 third load/store");
    go(5, "R2"); probe(5, 0, 0, 0, "R2 second float");
    newblk();
    go(5, "R2"); go(5, "R2"); probe(5, 0, 0, 1, "R2 third float");
    go(8, "R2"); probe(8, 0, 0, 1, "R2 second vec alu");
    newblk();
    go(9, "R2"); probe(9, 0, 0, 1, "R2 second vec perm");
    newblk();

    // R3 lead-only classes
    probe(6, 0, 0, 0, "R3 cr at slot 0");
    go(1, "R3");
    probe(6, 0, 0, 1, "R3 cr later");
    probe(7, 0, 0, 1, "R3 spr later");
    probe(2, 0, 0, 1, "R3 divide later");
    newblk();
    go(2, "R3"); probe(1, 0, 0, 0, "R3 fixed after divide");
    newblk();

    // R4 last slot, R5 branch closes
    go(1, "R4"); go(3, "R4"); go(5, "R4"); go(8, "R4");
    check(int'(slots), 4, "R4 four used");
    probe(9, 0, 0, 1, "R4 perm in fifth");
    probe(10, 0, 0, 0, "R4 branch in fifth");
    go(10, "R5");
    check(int'(slots), 0, "R5 closed");
    go(1, "R5"); go(10, "R5");
    check(int'(slots), 0, "R5 early close");
    probe(1, 0, 0, 0, "R5 counters fresh");

    // R6 counter register
    step(7, 1, 0, 1, 0, 0, 0, 0, 0, "R6 set ctr");
    probe(10, 1, 0, 2, "R6 branch via ctr");
    probe(10, 0, 0, 0, "R6 plain branch");
    newblk();
    probe(10, 1, 0, 0, "R6 no ctr set");

    // R7 overlap
    probe(3, 0, 1, 0, "R7 overlap no store");
    go(4, "R7");
    probe(3, 0, 1, 2, "R7 overlap after store");
    probe(3, 0, 0, 0, "R7 no overlap");
    // R10 priority
    go(3, "R10");
    probe(3, 0, 1, 1, "R10 hazard over noop");
    newblk();

    // R8 advance
    go(1, "R8"); go(1, "R8");
    step(0, 0, 1, 0, 0, 0, 0, 0, -1, "R8");
    step(0, 0, 1, 0, 0, 0, 0, 0, -1, "R8");
    check(int'(slots), 4, "R8 four after advances");
    step(0, 0, 1, 0, 0, 0, 0, 0, -1, "R8");
    check(int'(slots), 0, "R8 closed at five");
    probe(1, 0, 0, 0, "R8 counters cleared");

    // R9 pseudo
    go(1, "R9");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R9 pseudo 0");
    step(13, 1, 0, 0, 0, 0, 0, 0, 0, "R9 pseudo 13");
    check(int'(slots), 1, "R9 no state change");

    // R12 both strobes
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, "R12 issue+advance");
    check(int'(slots), 2, "R12 advance discarded");
    step(0, 1, 1, 0, 0, 0, 0, 0, 0, "R12 pseudo+advance");
    check(int'(slots), 2, "R12 nothing moved");
    newblk();

    // mixed traffic against the model
    for (int n = 0; n < 800; n++) begin
      int c;
      c = int'($urandom_range(0, 12));
      step(c, ($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 2),
           ($urandom_range(0, 3) == 0), $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 29) == 0), 1'b0, -1, "mixed R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule